// File: doc/BRIEF.md
# Column-Stripe Analog Scan Controller

This controller picks which matrix columns go to the eight analog test pads during an analog characterisation readout of a 960-column pixel array. In the scanning mode it routes a stripe of eight adjacent columns to the pads for one whole frame. At each frame boundary, signalled by a one-cycle strobe from the row sequencer, it moves the stripe eight columns to the right. After 120 frames every column has been read, and the controller starts over from the left edge.

In the fixed mode, a constant window of eight columns in the middle of the array stays on the pads, and the readout runs at the nominal rate instead of the slow scan rate. The mode input is sampled only on a frame strobe, so a frame already in progress is never cut short. The analog multiplexers and the pad drivers sit outside this block. They take the eight column indices and the rate flag as their control.

Top module: `colscan_ctrl`

## Requirements
- R1: After reset, the controller is in scanning mode with stripe index 0, `scan_done` low and `fast_rate` low.
- R2: In scanning mode, lane i of `col_sel` (bits 10*i+9 down to 10*i) carries column 8k+i, where k is the current stripe index.
- R3: In scanning mode, each `frame_done` strobe raises the stripe index by one on the next clock edge. Without a strobe the index holds. The index always stays in the range 0 to 119.
- R4: A strobe that ends stripe 119 returns the index to 0 and raises `scan_done` for exactly one clock cycle.
- R5: In fixed mode, lane i carries column 476+i (columns 476 to 483), the stripe index reads 0, and `frame_done` strobes change none of the outputs.
- R6: A change on `mode_fixed` has no effect until the next `frame_done` strobe. The new mode applies from the clock edge that samples that strobe.
- R7: A strobe that enters scanning mode from fixed mode starts the scan at stripe 0.
- R8: `fast_rate` is 1 while fixed mode is in effect (nominal readout rate) and 0 while scanning mode is in effect (slow readout rate).
- R9: A strobe that switches mode does not count as completing a stripe. It does not raise `scan_done`, even when the stripe index is 119.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fixed | input | 1 | Requested mode: 1 fixed window, 0 scanning |
| frame_done | input | 1 | One-cycle frame-boundary strobe from the row sequencer |
| stripe_idx | output | 7 | Current stripe index (0 to 119) |
| col_sel | output | 80 | Eight 10-bit column indices, lane i in bits 10*i+9:10*i |
| scan_done | output | 1 | One-cycle pulse after the last stripe has been read |
| fast_rate | output | 1 | 1 selects the nominal readout rate, 0 the slow scan rate |

## Verification
Every result is due one clock edge after the strobe that causes it: the new stripe index, the new column lanes, the new rate flag and the `scan_done` pulse. No output moves in any cycle without a strobe. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge that also clocks the design. It then compares all outputs on the following falling edge, so each expected value lines up with the single register stage of the design. Directed checks cover the cases where a stale value would hide a fault: the cycle right after the 120th strobe, a mode request held for several cycles without a strobe, and mode switches made both mid-scan and at stripe 119.

// File: rtl/colscan_ctrl.sv
module colscan_ctrl #(
  parameter int COLS     = 960,
  parameter int PADS     = 8,
  parameter int FIX_BASE = 476
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                mode_fixed,
  input  logic                                frame_done,
  output logic [$clog2(COLS/PADS)-1:0]        stripe_idx,
  output logic [PADS*$clog2(COLS)-1:0]        col_sel,
  output logic                                scan_done,
  output logic                                fast_rate
);
  localparam int STRIPES = COLS / PADS;
  localparam int SW      = $clog2(STRIPES);
  localparam int CW      = $clog2(COLS);
  localparam int LAST    = STRIPES - 1;

  logic          fixed_q;
  logic [SW-1:0] stripe_q;
  logic          done_q;

  wire switch_req = frame_done && (mode_fixed != fixed_q);
  wire at_last    = (stripe_q == SW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fixed_q  <= 1'b0;
      stripe_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (switch_req) begin
        fixed_q  <= mode_fixed;
        stripe_q <= '0;
      end else if (frame_done && !fixed_q) begin
        stripe_q <= at_last ? '0 : stripe_q + 1'b1;
        done_q   <= at_last;
      end
    end
  end

  for (genvar g = 0; g < PADS; g++) begin : g_lane
    assign col_sel[g*CW +: CW] = fixed_q ? CW'(FIX_BASE + g)
                                         : CW'(32'(stripe_q) * PADS + g);
  end

  assign stripe_idx = stripe_q;
  assign scan_done  = done_q;
  assign fast_rate  = fixed_q;
endmodule

module colscan_ctrl_chk #(
  parameter int STRIPES = 120,
  parameter int SW      = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_done,
  input logic [SW-1:0] stripe_idx,
  input logic          scan_done,
  input logic          fast_rate
);
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(stripe_idx) < STRIPES);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(stripe_idx));
  assert_rate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(fast_rate));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> (stripe_idx == '0) && (32'($past(stripe_idx)) == STRIPES - 1) && $past(frame_done));
  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);
  assert_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_rate |-> (stripe_idx == '0) && !scan_done);
endmodule

bind colscan_ctrl colscan_ctrl_chk #(.STRIPES(STRIPES), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
  .stripe_idx(stripe_idx), .scan_done(scan_done), .fast_rate(fast_rate));

// File: tb/colscan_ctrl_tb.sv
module colscan_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_fixed = 1'b0;
  logic       frame_done = 1'b0;
  logic [6:0] stripe_idx;
  logic [79:0] col_sel;
  logic       scan_done;
  logic       fast_rate;

  int checks = 0;
  int errors = 0;
  int m_fix = 0, m_stripe = 0, m_done = 0;

  always #2.5 clk = ~clk;

  colscan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_fixed(mode_fixed), .frame_done(frame_done),
    .stripe_idx(stripe_idx), .col_sel(col_sel), .scan_done(scan_done), .fast_rate(fast_rate));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lane(input int i);
    return int'(col_sel[i*10 +: 10]);
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fix = 0; m_stripe = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (frame_done) begin
        if (int'(mode_fixed) != m_fix) begin
          m_fix = int'(mode_fixed);
          m_stripe = 0;
        end else if (m_fix == 0) begin
          m_stripe = (m_stripe + 1) % 120;
          if (m_stripe == 0) m_done = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 stripe_idx", int'(stripe_idx), m_stripe);
      chk("R4 scan_done", int'(scan_done), m_done);
      chk("R8 fast_rate", int'(fast_rate), m_fix);
      for (int i = 0; i < 8; i++)
        chk(m_fix != 0 ? "R5 col_sel lane" : "R2 col_sel lane", lane(i),
            m_fix != 0 ? 476 + i : 8 * m_stripe + i);
    end
  end

  task automatic strobe();
    @(negedge clk) frame_done = 1'b1;
    @(negedge clk) frame_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset stripe", int'(stripe_idx), 0);
    chk("R1 reset scan_done", int'(scan_done), 0);
    chk("R1 reset fast_rate", int'(fast_rate), 0);
    chk("R1 reset lane0", lane(0), 0);

    for (int f = 0; f < 119; f++) begin
      strobe();
      idle(f % 3);
    end
    chk("R3 last stripe", int'(stripe_idx), 119);
    chk("R2 lane7 at stripe 119", lane(7), 959);
    strobe();
    chk("R4 wrap pulse", int'(scan_done), 1);
    chk("R4 wrap index", int'(stripe_idx), 0);
    idle(1);
    chk("R4 pulse one cycle", int'(scan_done), 0);

    @(negedge clk) frame_done = 1'b1;
    idle(3);
    frame_done = 1'b0;
    chk("R3 back-to-back strobes", int'(stripe_idx), 3);

    mode_fixed = 1'b1;
    idle(4);
    chk("R6 no early rate change", int'(fast_rate), 0);
    chk("R6 no early stripe change", int'(stripe_idx), 3);
    chk("R6 no early lane change", lane(0), 24);
    strobe();
    chk("R8 fixed rate", int'(fast_rate), 1);
    chk("R5 fixed lane0", lane(0), 476);
    chk("R5 fixed lane7", lane(7), 483);
    chk("R5 fixed stripe", int'(stripe_idx), 0);
    strobe();
    strobe();
    chk("R5 strobe ignored lane0", lane(0), 476);
    chk("R5 strobe ignored stripe", int'(stripe_idx), 0);

    mode_fixed = 1'b0;
    strobe();
    chk("R7 restart stripe", int'(stripe_idx), 0);
    chk("R9 no pulse on switch", int'(scan_done), 0);
    chk("R8 slow rate", int'(fast_rate), 0);

    for (int f = 0; f < 119; f++) strobe();
    chk("R3 at 119 again", int'(stripe_idx), 119);
    mode_fixed = 1'b1;
    strobe();
    chk("R9 switch at 119 no pulse", int'(scan_done), 0);
    chk("R5 fixed after 119", lane(0), 476);
    mode_fixed = 1'b0;
    strobe();
    chk("R7 restart after fixed", int'(stripe_idx), 0);
    idle(3);
    finish_run();
  end
endmodule